// File: doc/BRIEF.md
# Handshaked Backplane Register Target

This block is the target end of an asynchronous parallel backplane bus with a four-edge strobe/acknowledge handshake. Its window holds a small bank of 32-bit registers. The address strobe, the two data strobes and the write line come from the master's clock domain, so the block passes the strobes through two-flop synchronizers into its local clock. It latches the address, the 6-bit modifier, the long-word line and the direction once the synchronized address strobe goes low, and then decides whether the access is meant for it.

A selected single cycle moves 1, 2 or 4 bytes in big-endian order. The block answers with acknowledge, or with bus error when it cannot perform the access. A block transfer keeps the backplane address fixed. The target first acknowledges the address with a short pulse and then steps a local byte counter by 4 on each data beat. Any beat that would run past a 256-byte page is refused.

Top module: `bpslave`

## Requirements
- R1: A cycle is selected only when address bits 23 down to the window size (8 bits for 64 registers) equal `BASE`, and the modifier equals `AM_SINGLE` or `AM_BLOCK`. Address bits 31..24 are ignored. An unselected cycle gets neither acknowledge nor bus error, the data outputs are not driven, and no register changes.
- R2: The width is set by the active-high lane pair `dsl` = {ds1 low, ds0 low} and by `bus_lword_n`. With long-word high and dsl=11 the access is 2 bytes. With long-word high and dsl=10 it is 1 byte at the even byte. With dsl=01 it is 1 byte at the odd byte. With long-word low and dsl=11 it is 4 bytes.
- R3: Byte offset b inside a register word sits at bits [31-8b -: 8], which is big endian. A 4-byte access uses data[31:0]. A 2-byte access uses data[15:0], with the lower-address byte in [15:8]. A 1-byte access uses [15:8] for an even byte and [7:0] for an odd byte. Unused read lanes return 0.
- R4: On a selected, valid write, the data is stored and acknowledge asserts. Acknowledge or bus error stays asserted until both data strobes are seen high, and is then released.
- R5: Read data is driven (`bus_doe` high) only while acknowledge is asserted, and the drive stops once the data strobes are released.
- R6: Bus error instead of acknowledge is given for a 4-byte access with address bit 1 set, and for long-word low with only one data strobe.
- R7: With `AM_BLOCK`, the target acknowledges the address with a pulse `ADDR_ACK_CYC` clocks long. Each later data-strobe assertion is one 4-byte beat at the internal counter, which starts at the latched address and advances by 4 after every accepted beat.
- R8: A block beat that is not a 4-byte access gets bus error. Once the counter has passed the end of a 256-byte page, every further beat gets bus error.
- R9: After reset, both acknowledge and bus error are high (idle) and `bus_doe` is low. Acknowledge and bus error are never asserted together.
- R10: After its one beat, a single cycle ignores further data strobes until address strobe has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 31 | Backplane address bits 31..1 |
| bus_am | input | 6 | Address modifier |
| bus_lword_n | input | 1 | Long-word select, active low |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 2 | Data strobes {ds1, ds0}, active low |
| bus_write_n | input | 1 | Direction, low for write |
| bus_din | input | 32 | Data from the bus |
| bus_dout | output | 32 | Read data |
| bus_doe | output | 1 | Read data drive enable |
| bus_dtack_n | output | 1 | Acknowledge, active low |
| bus_berr_n | output | 1 | Bus error, active low |

## Verification
The bench builds the target with 64 registers, so the window and the 256-byte page are the same size. With `BASE` = 24'hA5C300 and `ADDR_ACK_CYC` = 3, a block started at offset 0xF8 reaches the page limit on its third beat. The lengthened address pulse can be told apart from a data acknowledge. Random single cycles with random upper address bits and occasional foreign windows or modifiers exercise the decode against a byte-level model.

// File: rtl/bpslave.sv
module bpslave #(
  parameter int          REG_WORDS    = 64,
  parameter logic [23:0] BASE         = 24'h340000,
  parameter logic [5:0]  AM_SINGLE    = 6'h39,
  parameter logic [5:0]  AM_BLOCK     = 6'h3B,
  parameter int          ADDR_ACK_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:1] bus_addr,
  input  logic [5:0]  bus_am,
  input  logic        bus_lword_n,
  input  logic        bus_as_n,
  input  logic [1:0]  bus_ds_n,
  input  logic        bus_write_n,
  input  logic [31:0] bus_din,
  output logic [31:0] bus_dout,
  output logic        bus_doe,
  output logic        bus_dtack_n,
  output logic        bus_berr_n
);
  localparam int OFFW = $clog2(REG_WORDS * 4);
  localparam int IW   = OFFW - 2;
  localparam int ACKW = $clog2(ADDR_ACK_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_AACK, S_WDS, S_SETTLE, S_RESP, S_DONE} st_t;

  st_t          st;
  logic [2:0]   sy1, sy2;
  logic [23:1]  cur_a;
  logic         is_blk, is_wr, lw, crossed, dtack_q, berr_q;
  logic [ACKW-1:0] acnt;
  logic [31:0]  rdata;
  logic [31:0]  mem [REG_WORDS];

  logic unused_hi;
  assign unused_hi = ^bus_addr[31:24];

  wire       as_l = !sy2[2];
  wire [1:0] ds_l = ~sy2[1:0];
  wire       hit  = (bus_addr[23:OFFW] == BASE[23:OFFW]) &&
                    (bus_am == AM_SINGLE || bus_am == AM_BLOCK);

  wire n4 = lw && ds_l == 2'b11;
  wire n2 = !lw && ds_l == 2'b11;
  wire n1 = !lw && (ds_l == 2'b01 || ds_l == 2'b10);
  wire a0 = n1 && ds_l == 2'b01;
  wire [1:0]    b   = {cur_a[1], a0};
  wire [IW-1:0] idx = cur_a[OFFW-1:2];
  wire bad = !(n4 || n2 || n1) || (n4 && cur_a[1]) ||
             (is_blk && (!n4 || crossed || cur_a[23:OFFW] != BASE[23:OFFW]));

  logic [31:0] rword, rsel, wdat;
  logic [7:0]  rbyte, wbyte;
  logic [15:0] rhalf;
  logic [3:0]  be;
  always_comb begin
    rword = mem[idx];
    rbyte = 8'(rword >> {~b, 3'b000});
    rhalf = cur_a[1] ? rword[15:0] : rword[31:16];
    rsel  = n4 ? rword : n2 ? {16'b0, rhalf} :
            a0 ? {24'b0, rbyte} : {16'b0, rbyte, 8'b0};
    wbyte = a0 ? bus_din[7:0] : bus_din[15:8];
    wdat  = n4 ? bus_din : n2 ? {2{bus_din[15:0]}} : {4{wbyte}};
    be    = n4 ? 4'hF : n2 ? (cur_a[1] ? 4'h3 : 4'hC) : (4'b1000 >> b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '1; sy2 <= '1;
    end else begin
      sy1 <= {bus_as_n, bus_ds_n};
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur_a <= '0; is_blk <= 1'b0; is_wr <= 1'b0; lw <= 1'b0;
      crossed <= 1'b0; dtack_q <= 1'b0; berr_q <= 1'b0; acnt <= '0; rdata <= '0;
      for (int i = 0; i < REG_WORDS; i++) mem[i] <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (as_l) begin
          if (hit) begin
            cur_a   <= bus_addr[23:1];
            is_blk  <= bus_am == AM_BLOCK;
            is_wr   <= !bus_write_n;
            lw      <= !bus_lword_n;
            crossed <= 1'b0;
            acnt    <= '0;
            if (bus_am == AM_BLOCK) begin
              dtack_q <= 1'b1;
              st      <= S_AACK;
            end else st <= S_WDS;
          end else st <= S_DONE;
        end
        S_AACK: begin
          acnt <= acnt + 1'b1;
          if (acnt == ACKW'(ADDR_ACK_CYC - 1)) begin
            dtack_q <= 1'b0;
            st      <= S_WDS;
          end
        end
        S_WDS: if (!as_l) st <= S_IDLE;
               else if (ds_l != 2'b00) st <= S_SETTLE;
        S_SETTLE: begin
          st <= S_RESP;
          if (bad) berr_q <= 1'b1;
          else begin
            dtack_q <= 1'b1;
            if (is_wr) begin
              for (int k = 0; k < 4; k++)
                if (be[k]) mem[idx][8*k +: 8] <= wdat[8*k +: 8];
            end else rdata <= rsel;
            if (is_blk) begin
              cur_a <= cur_a + 23'd2;
              if (cur_a[7:2] == 6'h3F) crossed <= 1'b1;
            end
          end
        end
        S_RESP: if (ds_l == 2'b00) begin
          dtack_q <= 1'b0;
          berr_q  <= 1'b0;
          st      <= is_blk ? S_WDS : S_DONE;
        end
        S_DONE: if (!as_l) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_dout    = rdata;
  assign bus_doe     = st == S_RESP && dtack_q && !is_wr;
  assign bus_dtack_n = !dtack_q;
  assign bus_berr_n  = !berr_q;

  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_dtack_n && !bus_berr_n));
  a_r5_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> $past(ds_l != 2'b00));
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESP && ds_l == 2'b00) |=> (bus_dtack_n && bus_berr_n));
  a_r7_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_dtack_n) |-> (ds_l != 2'b00 || st == S_AACK));
endmodule

// File: tb/bpslave_test.sv
module bpslave_test;
  localparam logic [23:0] BASE = 24'hA5C300;
  localparam logic [5:0]  AMS = 6'h39, AMB = 6'h3B;
  localparam int          AACK = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:1] bus_addr = '0;
  logic [5:0]  bus_am = '0;
  logic        bus_lword_n = 1'b1, bus_as_n = 1'b1, bus_write_n = 1'b1;
  logic [1:0]  bus_ds_n = 2'b11;
  logic [31:0] bus_din = '0, bus_dout;
  logic        bus_doe, bus_dtack_n, bus_berr_n;

  bpslave #(.REG_WORDS(64), .BASE(BASE), .AM_SINGLE(AMS), .AM_BLOCK(AMB),
            .ADDR_ACK_CYC(AACK)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit excl_bad = 0, done = 0;
  logic [31:0] ref_m [64];
  logic [31:0] blk_wd [8], blk_rd [8];
  int          blk_rs [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_up();
    end
  end

  task automatic wait_resp(output int r);
    r = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!bus_dtack_n && !bus_berr_n) excl_bad = 1;
      if (!bus_dtack_n) begin r = 1; break; end
      if (!bus_berr_n) begin r = 2; break; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (bus_dtack_n && bus_berr_n) break;
    end
  endtask

  task automatic beat(input logic [1:0] dsl, input logic [31:0] wd, input bit rd,
                      output int r, output logic [31:0] q, input string req);
    bus_din = wd;
    bus_ds_n = ~dsl;
    wait_resp(r);
    q = bus_dout;
    if (rd && r == 1) chk(bus_doe === 1'b1, "R5", {31'b0, bus_doe}, 1);
    bus_ds_n = 2'b11;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(bus_doe === 1'b0 && bus_dtack_n && bus_berr_n, req,
        {29'b0, bus_doe, bus_dtack_n, bus_berr_n}, 32'h3);
  endtask

  task automatic single(input logic [31:0] ba, input logic [5:0] am, input bit lw,
                        input logic [1:0] dsl, input bit wr, input logic [31:0] wd,
                        output int r, output logic [31:0] q);
    @(negedge clk);
    bus_addr = ba[31:1]; bus_am = am; bus_lword_n = !lw; bus_write_n = !wr;
    repeat (2) @(negedge clk);
    bus_as_n = 1'b0;
    repeat (2) @(negedge clk);
    beat(dsl, wd, !wr, r, q, "R4");
    bus_as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic block(input logic [31:0] ba, input bit wr, input int n, input logic [1:0] dsl);
    int r, w;
    logic [31:0] q;
    @(negedge clk);
    bus_addr = ba[31:1]; bus_am = AMB; bus_lword_n = 1'b0; bus_write_n = !wr;
    repeat (2) @(negedge clk);
    bus_as_n = 1'b0;
    wait_resp(r);
    w = 0;
    while (!bus_dtack_n && w < 20) begin @(negedge clk); w++; end
    chk(r == 1 && w >= AACK - 1 && w <= AACK, "R7", w, AACK);
    for (int i = 0; i < n; i++) begin
      beat(dsl, blk_wd[i], !wr, r, q, "R8");
      blk_rs[i] = r; blk_rd[i] = q;
    end
    bus_as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_resp(logic [31:0] ba, logic [5:0] am, bit lw, logic [1:0] dsl);
    if (ba[23:8] != BASE[23:8] || am != AMS) return 0;
    if (lw && dsl != 2'b11) return 2;
    if (lw && ba[1]) return 2;
    return 1;
  endfunction

  function automatic int boff(logic [31:0] ba, bit lw, logic [1:0] dsl);
    return {ba[7:1], (!lw && dsl == 2'b01)};
  endfunction

  function automatic logic [7:0] ref_byte(int off);
    logic [31:0] w = ref_m[off / 4];
    case (off % 4)
      0: return w[31:24];
      1: return w[23:16];
      2: return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  task automatic ref_put(int off, logic [7:0] v);
    case (off % 4)
      0: ref_m[off / 4][31:24] = v;
      1: ref_m[off / 4][23:16] = v;
      2: ref_m[off / 4][15:8]  = v;
      default: ref_m[off / 4][7:0] = v;
    endcase
  endtask

  task automatic ref_write(logic [31:0] ba, bit lw, logic [1:0] dsl, logic [31:0] d);
    int o = boff(ba, lw, dsl);
    if (lw) begin
      ref_put(o, d[31:24]); ref_put(o + 1, d[23:16]); ref_put(o + 2, d[15:8]); ref_put(o + 3, d[7:0]);
    end else if (dsl == 2'b11) begin
      ref_put(o, d[15:8]); ref_put(o + 1, d[7:0]);
    end else if (dsl == 2'b10) ref_put(o, d[15:8]);
    else ref_put(o, d[7:0]);
  endtask

  function automatic logic [31:0] ref_read(logic [31:0] ba, bit lw, logic [1:0] dsl);
    int o = boff(ba, lw, dsl);
    if (lw) return {ref_byte(o), ref_byte(o + 1), ref_byte(o + 2), ref_byte(o + 3)};
    if (dsl == 2'b11) return {16'b0, ref_byte(o), ref_byte(o + 1)};
    if (dsl == 2'b10) return {16'b0, ref_byte(o), 8'b0};
    return {24'b0, ref_byte(o)};
  endfunction

  task automatic do_single(logic [31:0] ba, logic [5:0] am, bit lw, logic [1:0] dsl,
                           bit wr, logic [31:0] wd, string req);
    int r, e;
    logic [31:0] q;
    e = exp_resp(ba, am, lw, dsl);
    single(ba, am, lw, dsl, wr, wd, r, q);
    chk(r == e, req, r, e);
    if (e == 1 && wr) ref_write(ba, lw, dsl, wd);
    if (e == 1 && !wr) chk(q === ref_read(ba, lw, dsl), req, q, ref_read(ba, lw, dsl));
  endtask

  localparam logic [31:0] W = {8'h00, BASE};

  initial begin
    int r;
    logic [31:0] q;
    int unused_seed = $urandom(32'h5eed);
    for (int i = 0; i < 64; i++) ref_m[i] = '0;
    repeat (3) @(negedge clk);
    chk(bus_dtack_n && bus_berr_n && !bus_doe, "R9",
        {29'b0, bus_dtack_n, bus_berr_n, bus_doe}, 32'h6);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_single(W + 32'h10, AMS, 1, 2'b11, 1, 32'h11223344, "R4");
    do_single(W + 32'h10, AMS, 1, 2'b11, 0, 0, "R3");
    do_single(W + 32'h10, AMS, 0, 2'b11, 0, 0, "R2");
    do_single(W + 32'h12, AMS, 0, 2'b11, 0, 0, "R3");
    do_single(W + 32'h12, AMS, 0, 2'b10, 0, 0, "R2");
    do_single(W + 32'h12, AMS, 0, 2'b01, 0, 0, "R2");
    do_single(W + 32'h11, AMS, 0, 2'b01, 1, 32'h0000_00A7, "R3");
    do_single(W + 32'h10, AMS, 1, 2'b11, 0, 0, "R3");
    do_single(W + 32'h10, 6'h09, 1, 2'b11, 1, 32'hDEADBEEF, "R1");
    do_single(W + 32'h10400, AMS, 1, 2'b11, 1, 32'hDEADBEEF, "R1");
    do_single(32'h7F00_0000 | (W + 32'h10), AMS, 1, 2'b11, 0, 0, "R1");
    do_single(W + 32'h10, AMS, 1, 2'b11, 0, 0, "R1");
    do_single(W + 32'h22, AMS, 1, 2'b11, 1, 32'h55555555, "R6");
    do_single(W + 32'h20, AMS, 1, 2'b01, 1, 32'h55555555, "R6");
    do_single(W + 32'h20, AMS, 1, 2'b11, 0, 0, "R6");

    // R10: second strobe within one address strobe is ignored
    @(negedge clk);
    bus_addr = (W + 32'h30) >> 1; bus_am = AMS; bus_lword_n = 1'b0; bus_write_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_as_n = 1'b0;
    repeat (2) @(negedge clk);
    beat(2'b11, 32'hCAFEF00D, 0, r, q, "R4");
    chk(r == 1, "R10", r, 1);
    beat(2'b11, 32'h0BADF00D, 0, r, q, "R10");
    chk(r == 0, "R10", r, 0);
    bus_as_n = 1'b1;
    repeat (4) @(negedge clk);
    ref_m[12] = 32'hCAFEF00D;
    do_single(W + 32'h30, AMS, 1, 2'b11, 0, 0, "R10");

    // R7 block write then read back
    for (int i = 0; i < 4; i++) blk_wd[i] = 32'hB0000000 + 32'(i * 32'h01010101);
    block(W + 32'h40, 1, 4, 2'b11);
    for (int i = 0; i < 4; i++) begin
      chk(blk_rs[i] == 1, "R7", blk_rs[i], 1);
      ref_m[16 + i] = blk_wd[i];
    end
    for (int i = 0; i < 4; i++) do_single(W + 32'(32'h40 + 4 * i), AMS, 1, 2'b11, 0, 0, "R7");
    block(W + 32'h44, 0, 3, 2'b11);
    for (int i = 0; i < 3; i++)
      chk(blk_rs[i] == 1 && blk_rd[i] === ref_m[17 + i], "R7", blk_rd[i], ref_m[17 + i]);

    // R8 page boundary and width in block
    blk_wd[0] = 32'h1; blk_wd[1] = 32'h2; blk_wd[2] = 32'h3; blk_wd[3] = 32'h4;
    block(W + 32'hF8, 1, 4, 2'b11);
    chk(blk_rs[0] == 1 && blk_rs[1] == 1, "R8", blk_rs[1], 1);
    chk(blk_rs[2] == 2 && blk_rs[3] == 2, "R8", blk_rs[2], 2);
    ref_m[62] = 32'h1; ref_m[63] = 32'h2;
    do_single(W + 32'h0, AMS, 1, 2'b11, 0, 0, "R8");
    do_single(W + 32'hFC, AMS, 1, 2'b11, 0, 0, "R8");
    block(W + 32'h80, 1, 1, 2'b10);
    chk(blk_rs[0] == 2, "R8", blk_rs[0], 2);

    // random single cycles
    for (int n = 0; n < 300; n++) begin
      logic [31:0] ba;
      logic [1:0]  dsl;
      logic [5:0]  am;
      bit lw, wr;
      int k = $urandom_range(0, 9);
      ba = {8'($urandom), BASE[23:8], 8'($urandom)} & 32'hFFFF_FFFE;
      if (k == 0) ba[23:8] = ba[23:8] ^ 16'h0100;
      am = (k == 1) ? 6'h0D : AMS;
      lw = $urandom_range(0, 2) == 0;
      dsl = 2'($urandom_range(1, 3));
      wr = $urandom_range(0, 1) == 1;
      do_single(ba, am, lw, dsl, wr, $urandom, "R2");
    end
    for (int i = 0; i < 64; i++) do_single(W + 32'(4 * i), AMS, 1, 2'b11, 0, 0, "R3");

    chk(!excl_bad, "R9", {31'b0, excl_bad}, 0);
    finish_up();
  end
endmodule